// File: doc/BRIEF.md
# Serial Device Address CRC Validator

This block sits on the host side of a single-wire bus. It receives a 64-bit device address one bit per accepted strobe, least significant bit first. It splits the address into three fields: an 8-bit family code, a 48-bit serial number and an 8-bit check byte. It runs a bit-serial CRC-8 over the first 56 bits and compares the result with the received check byte. It also compares the family code with a configured value.

A consumer pulses `start_i` before each address and then streams bits with `bit_valid_i`/`bit_data_i`. Gaps between bits are allowed. When the 64th bit has been taken, `done_o` pulses for one cycle, and the two verdicts stay on their outputs until the next start. A failed check only raises a flag. The block never stalls or aborts anything, so the consumer decides what to do with a bad address. `clear_i` returns the block to idle, and an idle block ignores bits.

Top module: `addr_crc_check`

## Requirements
- R1: After reset, or in the cycle after `clear_i`, `done_o`, `crc_ok_o`, `family_ok_o` and every field output are zero. Bits offered while the block is idle (no `start_i` since reset or clear) change no output.
- R2: `start_i` zeroes the bit counter, the CRC register, the captured fields and both verdicts. A bit offered in the same cycle as `start_i` is dropped. `clear_i` takes precedence over `start_i`.
- R3: Once armed, one bit is accepted on each rising edge with `bit_valid_i` high. Accepted bits 1–8 fill `family_o` with the first bit in bit 0. Bits 9–56 fill `serial_o` the same way, and bits 57–64 fill `crc_rx_o` the same way.
- R4: `crc_calc_o` starts at 0x00. For each of the first 56 accepted bits it takes one step: fb = crc[0] ^ bit, crc = (crc >> 1) ^ (fb ? 0x8C : 0x00). Bits 57–64 leave it unchanged.
- R5: `done_o` is high for exactly the one cycle that follows the edge that accepted the 64th bit.
- R6: With `done_o`, `crc_ok_o` is 1 exactly when the received check byte equals the computed CRC. `family_ok_o` is 1 exactly when the family code equals `EXP_FAMILY`, which defaults to 0x51. A mismatch does not stop the block.
- R7: `crc_ok_o` and `family_ok_o` keep their values until the next `start_i` or `clear_i`.
- R8: Bits offered after the 64th are ignored until the next `start_i`. They change no field or CRC and raise no further `done_o`.
- R9: An all-zero address gives a computed CRC of 0x00 and therefore `crc_ok_o` = 1, while `family_ok_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arm and zero the state for a new address |
| clear_i | input | 1 | Return to idle with all outputs zero |
| bit_valid_i | input | 1 | Address bit strobe |
| bit_data_i | input | 1 | Address bit value |
| done_o | output | 1 | One-cycle pulse when the address is complete |
| crc_ok_o | output | 1 | Received check byte matches computed CRC |
| family_ok_o | output | 1 | Family code matches `EXP_FAMILY` |
| family_o | output | 8 | Captured family code |
| serial_o | output | 48 | Captured serial number |
| crc_rx_o | output | 8 | Captured check byte |
| crc_calc_o | output | 8 | CRC computed over the first 56 bits |

## Verification
The assertions check several properties on every cycle: the counter never passes 64, an idle block keeps its counter still, start and clear zero the CRC register, each accepted bit lands in the top of its field register, the CRC holds still during the check-byte phase, `done_o` is a single-cycle pulse, and the verdicts stay steady between completions. Some behaviour can only be shown by the bench scenarios, because it needs whole addresses: that the CRC value is correct against a known address and against an independent byte-wise model, that gapped streams work, that restarts partway through an address behave, that a bit offered together with start is dropped, and that the all-zero case and trailing bits are handled.

// File: rtl/addr_crc_pkg.sv
package addr_crc_pkg;

  localparam int unsigned CRC_W = 8;

  typedef enum logic [1:0] {
    SEG_FAMILY = 2'd0,
    SEG_SERIAL = 2'd1,
    SEG_CHECK  = 2'd2,
    SEG_DONE   = 2'd3
  } seg_e;

  // One reflected bit-serial CRC step.
  function automatic logic [CRC_W-1:0] crc_bit_step(
    input logic [CRC_W-1:0] crc,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = crc[0] ^ din;
    crc_bit_step = (crc >> 1) ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/addr_bit_seq.sv
module addr_bit_seq
  import addr_crc_pkg::*;
#(
  parameter int unsigned FAM_W = 8,
  parameter int unsigned SER_W = 48,
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned CNT_W = $clog2(ADDR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             bit_valid_i,
  output logic             accept_o,
  output logic             last_o,
  output logic             armed_o,
  output seg_e             seg_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] FAM_END = CNT_W'(FAM_W);
  localparam logic [CNT_W-1:0] SER_END = CNT_W'(FAM_W + SER_W);
  localparam logic [CNT_W-1:0] ADR_END = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(ADDR_W - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = armed_q && bit_valid_i && !start_i && !clear_i;
  assign last_o   = (cnt_q == LAST_IX);
  assign armed_o  = armed_q;
  assign cnt_o    = cnt_q;

  always_comb begin
    if (cnt_q < FAM_END)      seg_o = SEG_FAMILY;
    else if (cnt_q < SER_END) seg_o = SEG_SERIAL;
    else if (cnt_q < ADR_END) seg_o = SEG_CHECK;
    else                      seg_o = SEG_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (accept_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) armed_q <= 1'b0;
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ADR_END);

  assert_idle_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_i && !clear_i) |=> $stable(cnt_q));

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i) |=> (armed_q && cnt_q == '0));

  assert_clear_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!armed_q && cnt_q == '0));

endmodule

// File: rtl/addr_crc_engine.sv
module addr_crc_engine
  import addr_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q;
  assign crc_o = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (step_i) crc_q <= crc_bit_step(crc_q, din_i, POLY);
  end

  assert_crc_zeroed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_q == '0));

  assert_crc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !step_i) |=> $stable(crc_q));

endmodule

// File: rtl/addr_field_cap.sv
module addr_field_cap #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;
  assign q_o = q_q;

  // LSB-first arrival: shift right, new bit enters at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= '0;
    else if (clr_i) q_q <= '0;
    else if (en_i)  q_q <= {din_i, q_q[W-1:1]};
  end

  assert_bit_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> (q_q[W-1] == $past(din_i)));

  assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(q_q));

endmodule

// File: rtl/addr_crc_check.sv
module addr_crc_check
  import addr_crc_pkg::*;
#(
  parameter int unsigned FAM_W = 8,
  parameter int unsigned SER_W = 48,
  parameter logic [FAM_W-1:0] EXP_FAMILY = 8'h51,
  parameter logic [CRC_W-1:0] POLY = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             bit_valid_i,
  input  logic             bit_data_i,
  output logic             done_o,
  output logic             crc_ok_o,
  output logic             family_ok_o,
  output logic [FAM_W-1:0] family_o,
  output logic [SER_W-1:0] serial_o,
  output logic [CRC_W-1:0] crc_rx_o,
  output logic [CRC_W-1:0] crc_calc_o
);

  localparam int unsigned ADDR_W = FAM_W + SER_W + CRC_W;
  localparam int unsigned CNT_W  = $clog2(ADDR_W + 1);

  logic             accept, last, armed, restart, finish;
  seg_e             seg;
  logic [CNT_W-1:0] cnt;
  logic             take_fam, take_ser, take_chk, crc_step;
  logic [CRC_W-1:0] crc_rx_next;

  assign restart  = start_i || clear_i;
  assign take_fam = accept && (seg == SEG_FAMILY);
  assign take_ser = accept && (seg == SEG_SERIAL);
  assign take_chk = accept && (seg == SEG_CHECK);
  assign crc_step = take_fam || take_ser;
  assign finish   = accept && last;
  assign crc_rx_next = {bit_data_i, crc_rx_o[CRC_W-1:1]};

  addr_bit_seq #(.FAM_W(FAM_W), .SER_W(SER_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .bit_valid_i(bit_valid_i), .accept_o(accept), .last_o(last),
    .armed_o(armed), .seg_o(seg), .cnt_o(cnt)
  );

  addr_crc_engine #(.POLY(POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .step_i(crc_step),
    .din_i(bit_data_i), .crc_o(crc_calc_o)
  );

  addr_field_cap #(.W(FAM_W)) u_fam (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(take_fam),
    .din_i(bit_data_i), .q_o(family_o)
  );

  addr_field_cap #(.W(SER_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(take_ser),
    .din_i(bit_data_i), .q_o(serial_o)
  );

  addr_field_cap #(.W(CRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(take_chk),
    .din_i(bit_data_i), .q_o(crc_rx_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      crc_ok_o    <= 1'b0;
      family_ok_o <= 1'b0;
    end else if (restart) begin
      done_o      <= 1'b0;
      crc_ok_o    <= 1'b0;
      family_ok_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        crc_ok_o    <= (crc_rx_next == crc_calc_o);
        family_ok_o <= (family_o == EXP_FAMILY);
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!armed && cnt == CNT_W'(ADDR_W)));

  assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish && !restart) |=> ($stable(crc_ok_o) && $stable(family_ok_o)));

  assert_verdict_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (crc_ok_o == (crc_rx_o == crc_calc_o)));

  assert_crc_frozen_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_chk && !restart) |=> $stable(crc_calc_o));

endmodule

// File: tb/test_addr_crc_check.sv
module test_addr_crc_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, clear_i = 1'b0;
  logic        bit_valid_i = 1'b0, bit_data_i = 1'b0;
  logic        done_o, crc_ok_o, family_ok_o;
  logic [7:0]  family_o, crc_rx_o, crc_calc_o;
  logic [47:0] serial_o;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  addr_crc_check i_addr_crc_check (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .done_o(done_o),
    .crc_ok_o(crc_ok_o), .family_ok_o(family_ok_o), .family_o(family_o),
    .serial_o(serial_o), .crc_rx_o(crc_rx_o), .crc_calc_o(crc_calc_o)
  );

  // Byte-oriented model: fold a whole byte in, then eight shifts.
  function automatic logic [7:0] model_crc(input logic [55:0] body);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < 7; b++) begin
      c ^= body[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [63:0] mk_addr(input logic [7:0] fam, input logic [47:0] ser);
    return {model_crc({ser, fam}), ser, fam};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // Drive bits [0..n-1]; if gap>0, idle gap cycles after every third bit.
  task automatic send(input logic [63:0] a, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin bit_valid_i = 1'b1; bit_data_i = a[i]; end
      if (gap > 0 && i % 3 == 2 && i != n - 1) begin
        @(negedge clk) bit_valid_i = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk) bit_valid_i = 1'b0;
  endtask

  task automatic check_fields(input string req, input logic [63:0] a);
    check(req, "family", 64'(family_o), 64'(a[7:0]));
    check(req, "serial", 64'(serial_o), 64'(a[55:8]));
    check(req, "crc_rx", 64'(crc_rx_o), 64'(a[63:56]));
    check(req, "crc_calc", 64'(crc_calc_o), 64'(model_crc(a[55:0])));
  endtask

  task automatic run_addr(input string req, input logic [63:0] a, input int gap,
                          input logic exp_crc, input logic exp_fam);
    pulse_start();
    send(a, 64, gap);
    check("R5", "done after 64th", 64'(done_o), 64'd1);
    check(req, "crc_ok", 64'(crc_ok_o), 64'(exp_crc));
    check(req, "family_ok", 64'(family_ok_o), 64'(exp_fam));
    check_fields("R3", a);
    @(negedge clk);
    check("R5", "done one cycle", 64'(done_o), 64'd0);
    check("R7", "crc_ok held", 64'(crc_ok_o), 64'(exp_crc));
  endtask

  task automatic t_reset();
    check("R1", "done", 64'(done_o), 64'd0);
    check("R1", "verdicts", 64'({crc_ok_o, family_ok_o}), 64'd0);
    check("R1", "fields", {family_o, crc_rx_o, serial_o}, 64'd0);
    send(64'hFFFF_FFFF_FFFF_FFFF, 10, 0);
    check("R1", "idle bits ignored", {family_o, crc_rx_o, serial_o}, 64'd0);
    check("R1", "idle crc", 64'(crc_calc_o), 64'd0);
  endtask

  task automatic t_known();
    logic [63:0] a = 64'hA2_00000001B81C_02;
    run_addr("R6", a, 0, 1'b1, 1'b0);
    check("R4", "known crc", 64'(crc_calc_o), 64'hA2);
  endtask

  task automatic t_good51();
    run_addr("R6", mk_addr(8'h51, 48'h1234_5678_9ABC), 2, 1'b1, 1'b1);
  endtask

  task automatic t_bad_crc();
    logic [63:0] a = mk_addr(8'h51, 48'hDEAD_BEEF_0042);
    a[60] = ~a[60];
    run_addr("R6", a, 0, 1'b0, 1'b1);
    check("R4", "crc ignores check byte", 64'(crc_calc_o), 64'(model_crc(a[55:0])));
  endtask

  task automatic t_zero();
    run_addr("R9", 64'd0, 0, 1'b1, 1'b0);
    check("R9", "zero crc", 64'(crc_calc_o), 64'd0);
  endtask

  task automatic t_extra();
    logic [63:0] a = mk_addr(8'h51, 48'h0F0F_F0F0_5A5A);
    run_addr("R6", a, 1, 1'b1, 1'b1);
    send(64'hFFFF_FFFF_FFFF_FFFF, 8, 0);
    check("R8", "no second done", 64'(done_o), 64'd0);
    check_fields("R8", a);
    check("R7", "verdicts held", 64'({crc_ok_o, family_ok_o}), 64'b11);
  endtask

  task automatic t_restart();
    logic [63:0] a = mk_addr(8'h51, 48'hA5A5_0001_7E7E);
    pulse_start();
    send(64'hFFFF_FFFF_FFFF_FFFF, 20, 0);
    // start together with a valid '1' bit: that bit must be dropped
    @(negedge clk) begin start_i = 1'b1; bit_valid_i = 1'b1; bit_data_i = 1'b1; end
    @(negedge clk) begin start_i = 1'b0; bit_valid_i = 1'b0; end
    check("R2", "restart zeroes fields", {family_o, crc_rx_o, serial_o}, 64'd0);
    check("R2", "restart zeroes crc", 64'(crc_calc_o), 64'd0);
    send(a, 64, 0);
    check("R2", "done after restart", 64'(done_o), 64'd1);
    check_fields("R2", a);
    check("R2", "verdicts after restart", 64'({crc_ok_o, family_ok_o}), 64'b11);
  endtask

  task automatic t_clear();
    pulse_start();
    send(64'h0123_4567_89AB_CDEF, 30, 0);
    @(negedge clk) begin clear_i = 1'b1; start_i = 1'b1; end
    @(negedge clk) begin clear_i = 1'b0; start_i = 1'b0; end
    check("R1", "clear fields", {family_o, crc_rx_o, serial_o}, 64'd0);
    check("R1", "clear verdicts", 64'({crc_ok_o, family_ok_o, done_o}), 64'd0);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64, 0);
    check("R2", "clear beats start, bits ignored", 64'(done_o), 64'd0);
    check("R1", "fields after clear", {family_o, crc_rx_o, serial_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_good51();
    t_bad_crc();
    t_zero();
    t_extra();
    t_restart();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule